// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a simple in-order fetch stage and runs one loop in hardware, so the loop needs no branch instruction. Software loads a loop start address, a loop end address and a 12-bit repeat count through three write strobes that share one data bus. The block then watches every fetched address. A pass through the loop body counts only if fetch reaches the detection slot and then moves on in order to the end instruction. When such a pass reaches the end address, the block does two things. It redirects fetch to the start address in the same cycle while iterations remain, and it lowers the count by one.

The detection slot depends on the length of the body. For a body of four or more 16-bit instructions, it is the instruction three slots before the end (end minus 6 bytes). For a shorter body, it is the start instruction. The block holds off holdable exceptions from the detection slot through the end instruction and releases them afterwards. Non-holdable exceptions are always passed on. There is one loop level and no stack. Software handles outer loops.

Top module: `hwloop_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the start address, the end address and the count to 0, and drives `redirect_valid` and `exc_hold` low.
- R2: The detection slot is `end - 6` when `end - start >= 6`, and `start` otherwise. A pass that reaches the end address without having fetched the detection slot gives no redirect and leaves the count unchanged.
- R3: When a recognized pass fetches the end address with a count greater than 1, `redirect_valid` is 1 and `redirect_addr` equals the start address in that same cycle. The count is one lower from the next cycle on.
- R4: When a recognized pass fetches the end address with a count of 1, there is no redirect, so fetch falls through, and the count becomes 0.
- R5: While the count is 0, `redirect_valid` and `exc_hold` stay low whatever is fetched.
- R6: A fetch flagged with `fetch_branch`, arriving after the detection slot and before or at the end address, cancels the current pass. That pass gives no redirect and leaves the count unchanged.
- R7: From the detection-slot fetch through the end-address fetch of a recognized pass, a pending holdable exception gives `exc_hold`=1 and `exc_take`=0. Outside that window it gives `exc_hold`=0 and `exc_take`=1.
- R8: A pending non-holdable exception gives `exc_take`=1 in every cycle, including inside the window.
- R9: A count write loads `wr_data[11:0]` on the next edge and discards any partly recognized pass. A following end fetch gives no redirect until the detection slot is fetched again.
- R10: Writes to start or end are accepted in any loop state, and a loop loaded afterwards runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start_en | input | 1 | Load loop start address from `wr_data` |
| wr_end_en | input | 1 | Load loop end address from `wr_data` |
| wr_count_en | input | 1 | Load repeat count from `wr_data[11:0]` |
| wr_data | input | 32 | Register write data |
| fetch_valid | input | 1 | A fetch occurs this cycle |
| fetch_branch | input | 1 | This fetch was reached by a branch or exception return |
| fetch_addr | input | 32 | Address being fetched |
| exc_hold_req | input | 1 | Holdable exception pending |
| exc_nohold_req | input | 1 | Non-holdable exception pending |
| redirect_valid | output | 1 | Next fetch must come from `redirect_addr` |
| redirect_addr | output | 32 | Loop start address |
| loop_count | output | 12 | Remaining repeat count |
| exc_hold | output | 1 | Holdable exception is being held off |
| exc_take | output | 1 | A pending exception may be accepted now |

## Verification
The bench runs loops of one to eight instructions. This covers the detection slot sitting at the start as well as the slot sitting three slots before the end. The counts range from 0 to 4. A design with the wrong detection offset would hold exceptions over the wrong cycles. A design that skipped sequential recognition would redirect from a pass that entered after the detection slot. The bench also injects branch arrivals after detection. A design that ignored them would redirect and decrement when it should leave the count alone. Count writes in the middle of a pass and end-address rewrites check that stale pass state does not leak into the next loop. Count values of 1 and 0 check the fall-through edge, where an off-by-one design would loop once more.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
    parameter int ADDR_W     = 32;
    parameter int CNT_W      = 12;
    parameter int INSN_BYTES = 2;
    parameter int DET_SLOTS  = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam addr_t DET_SPAN = addr_t'(DET_SLOTS * INSN_BYTES);

    typedef struct packed {
        addr_t start_a;
        addr_t end_a;
        cnt_t  count;
    } loop_cfg_t;

    typedef struct packed {
        logic  valid;
        logic  branch;
        addr_t addr;
    } fetch_t;

    // Long bodies detect DET_SLOTS slots before the end, short ones at the start.
    function automatic addr_t detect_addr(addr_t s, addr_t e);
        if ((e - s) >= DET_SPAN)
            return e - DET_SPAN;
        else
            return s;
    endfunction
endpackage

// File: rtl/hwloop_regs.sv
module hwloop_regs
    import hwloop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_start,
    input  logic      wr_end,
    input  logic      wr_count,
    input  addr_t     wr_data,
    input  logic      dec,
    output loop_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_start) cfg.start_a <= wr_data;
            if (wr_end)   cfg.end_a   <= wr_data;
            if (wr_count)
                cfg.count <= wr_data[CNT_W-1:0];
            else if (dec)
                cfg.count <= cfg.count - cnt_t'(1);
        end
    end
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
    import hwloop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fetch_t    f,
    input  loop_cfg_t cfg,
    input  logic      count_wr,
    output logic      window,
    output logic      end_pass,
    output logic      redirect
);
    logic  armed_q;
    logic  count_nz;
    logic  hit_det;
    logic  at_end;
    logic  armed_eff;
    addr_t det_a;

    assign det_a     = detect_addr(cfg.start_a, cfg.end_a);
    assign count_nz  = (cfg.count != '0);
    assign hit_det   = f.valid && count_nz && (f.addr == det_a);
    assign at_end    = f.valid && (f.addr == cfg.end_a);
    // A branch arrival anywhere but the detection slot breaks the pass.
    assign armed_eff = hit_det || (armed_q && !(f.valid && f.branch));

    assign window    = count_nz && armed_eff;
    assign end_pass  = at_end && count_nz && armed_eff;
    assign redirect  = end_pass && (cfg.count > cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst || count_wr)
            armed_q <= 1'b0;
        else if (!count_nz || at_end)
            armed_q <= 1'b0;
        else
            armed_q <= armed_eff;
    end
endmodule

// File: rtl/hwloop_excgate.sv
module hwloop_excgate (
    input  logic window,
    input  logic hold_req,
    input  logic nohold_req,
    output logic hold,
    output logic take
);
    assign hold = hold_req && window;
    assign take = nohold_req || (hold_req && !window);
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start_en,
    input  logic              wr_end_en,
    input  logic              wr_count_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              fetch_valid,
    input  logic              fetch_branch,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              exc_hold_req,
    input  logic              exc_nohold_req,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [CNT_W-1:0]  loop_count,
    output logic              exc_hold,
    output logic              exc_take
);
    loop_cfg_t cfg;
    fetch_t    fch;
    logic      window;
    logic      end_pass;

    assign fch.valid  = fetch_valid;
    assign fch.branch = fetch_branch;
    assign fch.addr   = fetch_addr;

    hwloop_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_start (wr_start_en),
        .wr_end   (wr_end_en),
        .wr_count (wr_count_en),
        .wr_data  (wr_data),
        .dec      (end_pass),
        .cfg      (cfg)
    );

    hwloop_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .f        (fch),
        .cfg      (cfg),
        .count_wr (wr_count_en),
        .window   (window),
        .end_pass (end_pass),
        .redirect (redirect_valid)
    );

    hwloop_excgate u_exc (
        .window     (window),
        .hold_req   (exc_hold_req),
        .nohold_req (exc_nohold_req),
        .hold       (exc_hold),
        .take       (exc_take)
    );

    assign redirect_addr = cfg.start_a;
    assign loop_count    = cfg.count;
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk
    import hwloop_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_count_en,
    input logic       fetch_valid,
    input logic       redirect_valid,
    input logic       exc_hold,
    input logic       exc_take,
    input logic       exc_hold_req,
    input logic       exc_nohold_req,
    input logic [CNT_W-1:0] loop_count
);
    AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (loop_count == '0) |-> !redirect_valid); // R5
    AST_IDLE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loop_count == '0) |-> !exc_hold); // R5
    AST_NOHOLD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        exc_nohold_req |-> exc_take); // R8
    AST_HOLD_OR_TAKE: assert property (@(posedge clk) disable iff (rst)
        (exc_hold_req && !exc_nohold_req) |-> (exc_hold != exc_take)); // R7
    AST_REDIRECT_DEC: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && !wr_count_en) |=> (loop_count == cnt_t'($past(loop_count) - cnt_t'(1)))); // R3
    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!fetch_valid && !wr_count_en) |=> $stable(loop_count)); // R9
endmodule

bind hwloop_ctrl hwloop_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_count_en    (wr_count_en),
    .fetch_valid    (fetch_valid),
    .redirect_valid (redirect_valid),
    .exc_hold       (exc_hold),
    .exc_take       (exc_take),
    .exc_hold_req   (exc_hold_req),
    .exc_nohold_req (exc_nohold_req),
    .loop_count     (loop_count)
);

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;
    import hwloop_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_start_en, wr_end_en, wr_count_en;
    addr_t       wr_data;
    logic        fetch_valid, fetch_branch;
    addr_t       fetch_addr;
    logic        exc_hold_req, exc_nohold_req;
    logic        redirect_valid;
    addr_t       redirect_addr;
    cnt_t        loop_count;
    logic        exc_hold, exc_take;

    int checks = 0;
    int errors = 0;

    hwloop_ctrl uut (
        .clk(clk), .rst(rst),
        .wr_start_en(wr_start_en), .wr_end_en(wr_end_en), .wr_count_en(wr_count_en),
        .wr_data(wr_data),
        .fetch_valid(fetch_valid), .fetch_branch(fetch_branch), .fetch_addr(fetch_addr),
        .exc_hold_req(exc_hold_req), .exc_nohold_req(exc_nohold_req),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .loop_count(loop_count), .exc_hold(exc_hold), .exc_take(exc_take)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus, set at the falling edge; outputs settle 2 ns later.
    task automatic drive(logic ws, logic we, logic wc, addr_t d,
                         logic fv, logic fb, addr_t fa, logic hr, logic nr);
        @(negedge clk);
        wr_start_en = ws; wr_end_en = we; wr_count_en = wc; wr_data = d;
        fetch_valid = fv; fetch_branch = fb; fetch_addr = fa;
        exc_hold_req = hr; exc_nohold_req = nr;
        #2;
    endtask

    task automatic idle();
        drive(0, 0, 0, '0, 0, 0, '0, 0, 0);
    endtask

    task automatic fetch(addr_t a, logic br, logic hr, logic nr);
        drive(0, 0, 0, '0, 1, br, a, hr, nr);
    endtask

    task automatic load(addr_t s, addr_t e, int n);
        drive(1, 0, 0, s, 0, 0, '0, 0, 0);
        drive(0, 1, 0, e, 0, 0, '0, 0, 0);
        drive(0, 0, 1, addr_t'(n), 0, 0, '0, 0, 0);
        idle();
    endtask

    function automatic int det_index(int len);
        return (len >= 4) ? len - 4 : 0;
    endfunction

    // Runs the loop body as a sequential program until it falls through.
    task automatic run_loop(addr_t s, int len, int n, int brk_pass);
        int    det  = det_index(len);
        int    cnt  = n;
        int    pass = 0;
        bit    done = 0;
        load(s, s + addr_t'(2 * (len - 1)), n);
        chk("R9", "count after load", loop_count, n);
        while (!done) begin
            bit broke = 0;
            for (int i = 0; i < len; i++) begin
                bit br  = (pass == brk_pass) && (i == det + 1);
                bit hr  = 1'($urandom % 2);
                bit win;
                bit red;
                if (br) broke = 1;
                fetch(s + addr_t'(2 * i), br, hr, 0);
                win = (cnt != 0) && !broke && (i >= det);
                red = (i == len - 1) && (cnt > 1) && !broke;
                chk(broke ? "R6" : (cnt == 0 ? "R5" : (cnt == 1 ? "R4" : "R3")),
                    "redirect_valid", redirect_valid, red);
                if (red) chk("R3", "redirect_addr", redirect_addr, s);
                chk(cnt == 0 ? "R5" : "R7", "exc_hold", exc_hold, hr && win);
                chk("R7", "exc_take", exc_take, hr && !win);
            end
            idle();
            if (broke || cnt == 0) done = 1;
            else if (cnt == 1) begin cnt = 0; done = 1; end
            else cnt--;
            chk(broke ? "R6" : (cnt == 0 ? "R4" : "R3"), "count after pass", loop_count, cnt);
            pass++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        wr_start_en = 0; wr_end_en = 0; wr_count_en = 0; wr_data = '0;
        fetch_valid = 0; fetch_branch = 0; fetch_addr = '0;
        exc_hold_req = 0; exc_nohold_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1", "count after reset", loop_count, 0);
        chk("R1", "redirect after reset", redirect_valid, 0);
        chk("R1", "hold after reset", exc_hold, 0);
        // Start=end=0 after reset: a fetch at 0 with count 0 gives no loop.
        fetch(32'h0, 0, 1, 0);
        chk("R1", "redirect at addr 0", redirect_valid, 0);
        chk("R5", "hold at addr 0 idle", exc_hold, 0);
        chk("R7", "take at addr 0 idle", exc_take, 1);
        idle();

        // R2: long body (6 insns, detect at index 2); enter at index 3.
        load(32'h200, 32'h20A, 3);
        for (int i = 3; i < 6; i++) fetch(32'h200 + addr_t'(2 * i), 0, 1, 0);
        chk("R2", "no redirect without detection", redirect_valid, 0);
        chk("R2", "no hold without detection", exc_hold, 0);
        idle();
        chk("R2", "count kept", loop_count, 3);

        // R8: non-holdable taken inside the window.
        for (int i = 0; i < 5; i++) fetch(32'h200 + addr_t'(2 * i), 0, 1, 1);
        chk("R8", "nohold take in window", exc_take, 1);
        chk("R7", "hold in window", exc_hold, 1);
        idle();

        // R9: count write mid-pass drops the pass.
        load(32'h300, 32'h30A, 3);
        for (int i = 0; i < 4; i++) fetch(32'h300 + addr_t'(2 * i), 0, 0, 0);
        drive(0, 0, 1, addr_t'(2), 0, 0, '0, 0, 0);
        idle();
        chk("R9", "count rewritten", loop_count, 2);
        fetch(32'h308, 0, 0, 0);
        fetch(32'h30A, 0, 1, 0);
        chk("R9", "no redirect after rewrite", redirect_valid, 0);
        chk("R9", "no hold after rewrite", exc_hold, 0);
        idle();
        chk("R9", "count unchanged", loop_count, 2);
        for (int i = 0; i < 6; i++) fetch(32'h300 + addr_t'(2 * i), 0, 0, 0);
        chk("R9", "redirect on fresh pass", redirect_valid, 1);
        idle();
        chk("R9", "count decremented", loop_count, 1);

        // R10: rewrite end mid-pass, then a new loop runs normally.
        load(32'h400, 32'h40E, 4);
        for (int i = 0; i < 6; i++) fetch(32'h400 + addr_t'(2 * i), 0, 0, 0);
        drive(0, 1, 0, 32'h404, 0, 0, '0, 0, 0);
        idle();
        run_loop(32'h400, 3, 2, -1);
        chk("R10", "loop done after rewrite", loop_count, 0);

        // Directed corner lengths, then random loops.
        run_loop(32'h500, 1, 3, -1);
        run_loop(32'h600, 4, 2, 0);
        run_loop(32'h700, 8, 1, -1);
        run_loop(32'h800, 5, 0, -1);
        for (int k = 0; k < 30; k++) begin
            addr_t s   = 32'h1000 + addr_t'(($urandom % 256) * 2);
            int    len = 1 + int'($urandom % 8);
            int    n   = int'($urandom % 5);
            int    brk = ($urandom % 3 == 0) ? int'($urandom % 3) : -1;
            run_loop(s, len, n, brk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule